// File: doc/BRIEF.md
# Two-level GPU address translation walker

This block turns a 31-bit GPU virtual address into a 32-bit bus address. Pages are 4 KB and the virtual space is 2 GB. Two ways of finding the page frame share one walker. In global mode it reads one 4-byte entry from a single-level table. That table is 2 MB of contiguous memory that starts at the parameter `GT_BASE`. In per-process mode it walks a two-level table. The 512 directory entries sit in the top 512 slots of the global table, which shrinks the usable global range by 2 MB. Each directory entry points at a 4 KB leaf page of 1024 entries. Leaf entries have the same layout as global entries, so one decoder serves both levels.

A requester presents an address and a mode through a valid/ready handshake and receives a single-cycle response that carries the bus address or a fault flag. Table entries come from a word-read port: a request is held until it is granted, and its data returns after any number of cycles. A four-entry, fully associative translation cache keeps recent successful translations. A one-cycle flush pulse empties it.

The control is one state machine. Its states are IDLE, LOOKUP, DIR_REQ, DIR_WAIT, LEAF_REQ, LEAF_WAIT and RESP.
- IDLE goes to LOOKUP when a request is accepted.
- LOOKUP goes to RESP on a cache hit or on a reserved global index. Otherwise it goes to DIR_REQ in per-process mode, or to LEAF_REQ in global mode.
- DIR_REQ goes to DIR_WAIT on grant.
- DIR_WAIT goes to RESP when the returned entry is invalid, and to LEAF_REQ when it is valid.
- LEAF_REQ goes to LEAF_WAIT on grant.
- LEAF_WAIT goes to RESP when the data returns.
- RESP always returns to IDLE.

Top module: `addr_xlate_walker`

## Requirements
- R1: While reset is high and just after it, `req_ready` is 1, `rsp_valid` is 0 and `rd_req` is 0.
- R2: In global mode (`req_mode`=0) a cache miss issues one read at `GT_BASE + va[30:12]*4`. A valid entry yields `rsp_pa = {entry[31:12], va[11:0]}`.
- R3: In per-process mode (`req_mode`=1) a miss first reads the directory entry at `GT_BASE + (2^19 - 512 + va[30:22])*4`. It then reads the leaf entry at `{dir[31:12], va[21:12], 2'b00}`. The result is `rsp_pa = {leaf[31:12], va[11:0]}`.
- R4: An entry whose bit 0 is 0 is invalid at either level. It ends the walk with `rsp_fault`=1 and `rsp_pa`=0, and no further read is issued.
- R5: A global-mode request whose index `va[30:12]` is at or above `2^19 - 512` falls in the directory slice. It faults without any read.
- R6: `req_ready` is low from the accepting edge until the response cycle has ended. Every accepted request gets exactly one `rsp_valid` pulse, one cycle long.
- R7: Successful translations are cached, tagged with mode and page number. A hit issues no read and raises `rsp_valid` on the first rising edge after the accepting edge. Faults are never cached.
- R8: The cache holds 4 entries and fills them round-robin, so the fifth distinct fill evicts the oldest.
- R9: A `flush` pulse clears every cache entry by the next edge and resets the fill pointer. The following request for a previously cached page walks again.
- R10: If `flush` arrives during a walk, that walk still returns its result, but the result is not cached.
- R11: `rd_req` holds with a stable `rd_addr` until `rd_gnt`. No new read is requested before the previous one has returned `rd_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_va | input | 31 | Virtual address to translate |
| req_mode | input | 1 | 0 = global single-level, 1 = per-process two-level |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation failed |
| rsp_pa | output | 32 | Translated bus address (0 on fault) |
| flush | input | 1 | Empty the translation cache |
| rd_req | output | 1 | Table read request |
| rd_addr | output | 32 | Byte address of the table entry |
| rd_gnt | input | 1 | Read request taken |
| rd_rvalid | input | 1 | Read data returned |
| rd_rdata | input | 32 | Table entry |

## Verification
The assertions check several rules on every cycle:
- the handshake rules: ready drops after an accept, one response pulse, and no response without a pending request;
- the read port rules: a held and stable address until grant, and one read outstanding;
- the zero address on faults and the passthrough of the page offset;
- that reserved global indices never reach memory;
- that a flush empties the cache.

Only the bench scenarios can show the rest: the computed table addresses at both levels, the read counts of hits, the round-robin eviction order, that faults are not cached, and that a result is dropped when its walk saw a flush. The bench compares these against a behavioural model under varied grant and data latencies.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    // Walker control states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_LEAF_REQ,
        ST_LEAF_WAIT,
        ST_RESP
    } xw_state_e;

    // Position of the present flag in every table entry
    localparam int ENTRY_OK_BIT = 0;
    // log2 of the table entry size in bytes
    localparam int ENTRY_SHIFT  = 2;

endpackage

// File: rtl/xlate_addr_gen.sv
module xlate_addr_gen #(
    parameter int VA_W  = 31,
    parameter int PA_W  = 32,
    parameter int OFF_W = 12,
    parameter int DIR_W = 9,
    parameter logic [PA_W-1:0] GT_BASE = 32'h0800_0000
) (
    input  logic [VA_W-1:0]       va,
    input  logic [PA_W-OFF_W-1:0] dir_frame,
    output logic [PA_W-1:0]       glob_addr,
    output logic [PA_W-1:0]       dir_addr,
    output logic [PA_W-1:0]       leaf_addr,
    output logic                  reserved
);
    import xlate_pkg::*;

    localparam int GIDX_W   = VA_W - OFF_W;
    localparam int LEAF_W   = GIDX_W - DIR_W;
    localparam int DIR_SLOT = (1 << GIDX_W) - (1 << DIR_W);

    logic [GIDX_W-1:0] gidx;
    logic [DIR_W-1:0]  didx;
    logic [LEAF_W-1:0] lidx;

    assign gidx = va[VA_W-1:OFF_W];
    assign didx = va[VA_W-1:VA_W-DIR_W];
    assign lidx = va[OFF_W+LEAF_W-1:OFF_W];

    // Flat global entry
    assign glob_addr = GT_BASE + (PA_W'(gidx) << ENTRY_SHIFT);
    // Directory slice at the top of the global table
    assign dir_addr  = GT_BASE + ((PA_W'(DIR_SLOT) + PA_W'(didx)) << ENTRY_SHIFT);
    // Leaf entry inside the page named by the directory entry
    assign leaf_addr = {dir_frame, OFF_W'({lidx, 2'b00})};
    // Global indices that overlap the directory slice
    assign reserved  = (gidx >= GIDX_W'(DIR_SLOT));

endmodule

// File: rtl/xlate_cache.sv
module xlate_cache #(
    parameter int N      = 4,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    output logic [N-1:0]      valid_vec
);
    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

    logic [TAG_W-1:0]  tag_q  [N];
    logic [DATA_W-1:0] data_q [N];
    logic [N-1:0]      vld_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [N-1:0]      match;

    // Per-entry comparators
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign match[g] = vld_q[g] && (tag_q[g] == lk_tag);
        end
    endgenerate

    assign lk_hit    = |match;
    assign valid_vec = vld_q;

    always_comb begin
        lk_data = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) lk_data = data_q[i];
        end
    end

    // Storage; flush has priority over fill
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            ptr_q <= '0;
            for (int i = 0; i < N; i++) begin
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end
        end else if (flush) begin
            vld_q <= '0;
            ptr_q <= '0;
        end else if (fill_en) begin
            for (int i = 0; i < N; i++) begin
                if (ptr_q == PTR_W'(i)) begin
                    vld_q[i]  <= 1'b1;
                    tag_q[i]  <= fill_tag;
                    data_q[i] <= fill_data;
                end
            end
            ptr_q <= (ptr_q == PTR_W'(N - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

endmodule

// File: rtl/xlate_fsm.sv
module xlate_fsm #(
    parameter int VA_W  = 31,
    parameter int PA_W  = 32,
    parameter int OFF_W = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [VA_W-1:0]       req_va,
    input  logic                  req_mode,
    input  logic                  flush,
    input  logic                  hit,
    input  logic [PA_W-OFF_W-1:0] hit_frame,
    input  logic                  reserved,
    input  logic [PA_W-1:0]       glob_addr,
    input  logic [PA_W-1:0]       dir_addr,
    input  logic [PA_W-1:0]       leaf_addr,
    input  logic                  rd_gnt,
    input  logic                  rd_rvalid,
    input  logic [PA_W-1:0]       rd_rdata,
    output logic                  req_ready,
    output logic                  rsp_valid,
    output logic                  rsp_fault,
    output logic [PA_W-1:0]       rsp_pa,
    output logic                  rd_req,
    output logic [PA_W-1:0]       rd_addr,
    output logic [VA_W-1:0]       va_q,
    output logic                  mode_q,
    output logic [PA_W-OFF_W-1:0] dir_frame_q,
    output logic                  fill_en,
    output logic [PA_W-OFF_W-1:0] fill_frame
);
    import xlate_pkg::*;

    xw_state_e             state_q, state_d;
    logic [PA_W-OFF_W-1:0] frame_q;
    logic                  fault_q;
    logic                  stale_q;
    logic                  accept;
    logic                  hit_ok;
    logic                  entry_ok;

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign hit_ok   = hit && !flush;
    assign entry_ok = rd_rdata[ENTRY_OK_BIT];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (hit_ok)                  state_d = ST_RESP;
                else if (!mode_q && reserved) state_d = ST_RESP;
                else if (mode_q)             state_d = ST_DIR_REQ;
                else                         state_d = ST_LEAF_REQ;
            end
            ST_DIR_REQ:   if (rd_gnt) state_d = ST_DIR_WAIT;
            ST_DIR_WAIT:  if (rd_rvalid) state_d = entry_ok ? ST_LEAF_REQ : ST_RESP;
            ST_LEAF_REQ:  if (rd_gnt) state_d = ST_LEAF_WAIT;
            ST_LEAF_WAIT: if (rd_rvalid) state_d = ST_RESP;
            ST_RESP:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Walk datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            va_q        <= '0;
            mode_q      <= 1'b0;
            stale_q     <= 1'b0;
            frame_q     <= '0;
            fault_q     <= 1'b0;
            dir_frame_q <= '0;
        end else begin
            if (accept) begin
                va_q    <= req_va;
                mode_q  <= req_mode;
                stale_q <= 1'b0;
            end else if (flush) begin
                stale_q <= 1'b1;
            end
            case (state_q)
                ST_LOOKUP: begin
                    if (hit_ok) begin
                        frame_q <= hit_frame;
                        fault_q <= 1'b0;
                    end else if (!mode_q && reserved) begin
                        frame_q <= '0;
                        fault_q <= 1'b1;
                    end
                end
                ST_DIR_WAIT: begin
                    if (rd_rvalid) begin
                        if (entry_ok) begin
                            dir_frame_q <= rd_rdata[PA_W-1:OFF_W];
                        end else begin
                            frame_q <= '0;
                            fault_q <= 1'b1;
                        end
                    end
                end
                ST_LEAF_WAIT: begin
                    if (rd_rvalid) begin
                        fault_q <= !entry_ok;
                        frame_q <= entry_ok ? rd_rdata[PA_W-1:OFF_W] : '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        rsp_valid  = (state_q == ST_RESP);
        rsp_fault  = (state_q == ST_RESP) && fault_q;
        rsp_pa     = ((state_q == ST_RESP) && !fault_q) ? {frame_q, va_q[OFF_W-1:0]} : '0;
        rd_req     = (state_q == ST_DIR_REQ) || (state_q == ST_LEAF_REQ);
        rd_addr    = '0;
        if (state_q == ST_DIR_REQ)       rd_addr = dir_addr;
        else if (state_q == ST_LEAF_REQ) rd_addr = mode_q ? leaf_addr : glob_addr;
        fill_en    = (state_q == ST_LEAF_WAIT) && rd_rvalid && entry_ok && !stale_q && !flush;
        fill_frame = rd_rdata[PA_W-1:OFF_W];
    end

endmodule

// File: rtl/addr_xlate_walker.sv
module addr_xlate_walker #(
    parameter int VA_W  = 31,
    parameter int PA_W  = 32,
    parameter int OFF_W = 12,
    parameter int DIR_W = 9,
    parameter int TLB_N = 4,
    parameter logic [PA_W-1:0] GT_BASE = 32'h0800_0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_va,
    input  logic            req_mode,
    output logic            rsp_valid,
    output logic            rsp_fault,
    output logic [PA_W-1:0] rsp_pa,
    input  logic            flush,
    output logic            rd_req,
    output logic [PA_W-1:0] rd_addr,
    input  logic            rd_gnt,
    input  logic            rd_rvalid,
    input  logic [PA_W-1:0] rd_rdata
);
    localparam int FRAME_W = PA_W - OFF_W;
    localparam int TAG_W   = VA_W - OFF_W + 1;

    logic [VA_W-1:0]    va_q;
    logic               mode_q;
    logic [FRAME_W-1:0] dir_frame_q;
    logic [FRAME_W-1:0] fill_frame;
    logic [FRAME_W-1:0] hit_frame;
    logic               fill_en;
    logic               hit;
    logic               reserved;
    logic [PA_W-1:0]    glob_addr;
    logic [PA_W-1:0]    dir_addr;
    logic [PA_W-1:0]    leaf_addr;
    logic [TAG_W-1:0]   cur_tag;
    logic [TLB_N-1:0]   tlb_valid;

    assign cur_tag = {mode_q, va_q[VA_W-1:OFF_W]};

    xlate_addr_gen #(
        .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .DIR_W(DIR_W), .GT_BASE(GT_BASE)
    ) u_agen (
        .va        (va_q),
        .dir_frame (dir_frame_q),
        .glob_addr (glob_addr),
        .dir_addr  (dir_addr),
        .leaf_addr (leaf_addr),
        .reserved  (reserved)
    );

    xlate_cache #(
        .N(TLB_N), .TAG_W(TAG_W), .DATA_W(FRAME_W)
    ) u_cache (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .lk_tag    (cur_tag),
        .lk_hit    (hit),
        .lk_data   (hit_frame),
        .fill_en   (fill_en),
        .fill_tag  (cur_tag),
        .fill_data (fill_frame),
        .valid_vec (tlb_valid)
    );

    xlate_fsm #(
        .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_va      (req_va),
        .req_mode    (req_mode),
        .flush       (flush),
        .hit         (hit),
        .hit_frame   (hit_frame),
        .reserved    (reserved),
        .glob_addr   (glob_addr),
        .dir_addr    (dir_addr),
        .leaf_addr   (leaf_addr),
        .rd_gnt      (rd_gnt),
        .rd_rvalid   (rd_rvalid),
        .rd_rdata    (rd_rdata),
        .req_ready   (req_ready),
        .rsp_valid   (rsp_valid),
        .rsp_fault   (rsp_fault),
        .rsp_pa      (rsp_pa),
        .rd_req      (rd_req),
        .rd_addr     (rd_addr),
        .va_q        (va_q),
        .mode_q      (mode_q),
        .dir_frame_q (dir_frame_q),
        .fill_en     (fill_en),
        .fill_frame  (fill_frame)
    );

endmodule

// File: rtl/xlate_walker_chk.sv
module xlate_walker_chk #(
    parameter int VA_W  = 31,
    parameter int PA_W  = 32,
    parameter int OFF_W = 12,
    parameter int DIR_W = 9,
    parameter int TLB_N = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [VA_W-1:0]  req_va,
    input logic             req_mode,
    input logic             rsp_valid,
    input logic             rsp_fault,
    input logic [PA_W-1:0]  rsp_pa,
    input logic             flush,
    input logic             rd_req,
    input logic [PA_W-1:0]  rd_addr,
    input logic             rd_gnt,
    input logic             rd_rvalid,
    input logic [TLB_N-1:0] tlb_valid
);
    localparam int GIDX_W   = VA_W - OFF_W;
    localparam int DIR_SLOT = (1 << GIDX_W) - (1 << DIR_W);

    logic            pending_q;
    logic            rd_out_q;
    logic            cmode_q;
    logic [VA_W-1:0] cva_q;
    logic            creserved;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
            rd_out_q  <= 1'b0;
            cmode_q   <= 1'b0;
            cva_q     <= '0;
        end else begin
            if (req_valid && req_ready) begin
                pending_q <= 1'b1;
                cva_q     <= req_va;
                cmode_q   <= req_mode;
            end else if (rsp_valid) begin
                pending_q <= 1'b0;
            end
            if (rd_req && rd_gnt)  rd_out_q <= 1'b1;
            else if (rd_rvalid)    rd_out_q <= 1'b0;
        end
    end

    assign creserved = (cva_q[VA_W-1:OFF_W] >= GIDX_W'(DIR_SLOT));

    // R6: no new accept right after an accept
    p_accept_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
    // R6: response strobe is one cycle long
    p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    // R6: every response belongs to an accepted request
    p_rsp_pending_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> pending_q);
    // R11: request held with stable address until grant
    p_addr_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_gnt) |=> (rd_req && $stable(rd_addr)));
    // R11: single read outstanding
    p_single_read_r11: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> !rd_out_q);
    // R4: faulting response carries a zero address
    p_fault_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_pa == '0));
    // R2: page offset passes through unchanged
    p_offset_r2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (rsp_pa[OFF_W-1:0] == cva_q[OFF_W-1:0]));
    // R5: reserved global index never reaches memory
    p_reserved_noread_r5: assert property (@(posedge clk) disable iff (rst)
        (pending_q && !cmode_q && creserved) |-> !rd_req);
    // R9: flush empties the cache by the next edge
    p_flush_clear_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (tlb_valid == '0));

endmodule

bind addr_xlate_walker xlate_walker_chk #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .DIR_W(DIR_W), .TLB_N(TLB_N)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_va    (req_va),
    .req_mode  (req_mode),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_pa    (rsp_pa),
    .flush     (flush),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_gnt    (rd_gnt),
    .rd_rvalid (rd_rvalid),
    .tlb_valid (tlb_valid)
);

// File: tb/sim_addr_xlate_walker.sv
`timescale 1ns/1ps
module sim_addr_xlate_walker;
    localparam int VA_W  = 31;
    localparam int PA_W  = 32;
    localparam int OFF_W = 12;
    localparam int DIR_W = 9;
    localparam int TLB_N = 4;
    localparam logic [31:0] GT_BASE = 32'h0800_0000;
    localparam int GIDX_W   = VA_W - OFF_W;
    localparam int DIR_SLOT = (1 << GIDX_W) - (1 << DIR_W);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [VA_W-1:0] req_va = '0;
    logic            req_mode = 1'b0;
    logic            rsp_valid;
    logic            rsp_fault;
    logic [PA_W-1:0] rsp_pa;
    logic            flush = 1'b0;
    logic            rd_req;
    logic [PA_W-1:0] rd_addr;
    logic            rd_gnt = 1'b0;
    logic            rd_rvalid = 1'b0;
    logic [PA_W-1:0] rd_rdata = '0;

    always #10 clk = ~clk;

    addr_xlate_walker u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_mode(req_mode), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_pa(rsp_pa), .flush(flush),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_gnt(rd_gnt),
        .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit busy_m = 1'b0;

    logic [31:0] mem [logic [31:0]];
    logic [31:0] rdq [$];

    // Model cache
    logic [19:0] mtag [TLB_N];
    logic [19:0] mfrm [TLB_N];
    bit          mval [TLB_N];
    int          mptr = 0;

    function automatic logic [31:0] rdmem(logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < TLB_N; i++) mval[i] = 1'b0;
        mptr = 0;
    endtask

    // Memory responder with varying grant and data latency
    initial begin : responder
        logic [31:0] a;
        int k;
        k = 0;
        forever begin
            @(negedge clk);
            rd_gnt = 1'b0;
            rd_rvalid = 1'b0;
            if (rd_req) begin
                repeat (k % 3) @(negedge clk);
                a = rd_addr;
                rdq.push_back(a);
                rd_gnt = 1'b1;
                @(negedge clk);
                rd_gnt = 1'b0;
                repeat (k % 4) @(negedge clk);
                rd_rvalid = 1'b1;
                rd_rdata = rdmem(a);
                k++;
            end
        end
    end

    // Every-cycle comparison against model busy flag (R6)
    always begin
        @(negedge clk);
        #3;
        if (!rst) begin
            chk(!(rsp_valid && !busy_m), "R6", "response without request", 64'(rsp_valid), 64'(0));
            if (busy_m) chk(!req_ready, "R6", "ready during walk", 64'(req_ready), 64'(0));
        end
    end

    task automatic xlate(input logic [VA_W-1:0] va, input bit mode, input bit fl_mid, input string want);
        logic [GIDX_W-1:0] gidx;
        logic [19:0] tag, frm;
        logic [31:0] epa, a1, a2, d, e;
        logic [31:0] ea [$];
        bit hit, efault, resv;
        int cyc;
        string lbl;
        gidx = va[VA_W-1:OFF_W];
        tag = {mode, gidx};
        hit = 1'b0; resv = 1'b0; efault = 1'b0; frm = '0; epa = '0;
        for (int i = 0; i < TLB_N; i++)
            if (mval[i] && mtag[i] == tag) begin hit = 1'b1; frm = mfrm[i]; end
        if (hit) begin
            epa = {frm, va[11:0]};
        end else if (!mode && int'(gidx) >= DIR_SLOT) begin
            resv = 1'b1; efault = 1'b1;
        end else if (!mode) begin
            a1 = GT_BASE + 32'(int'(gidx) * 4);
            ea.push_back(a1);
            e = rdmem(a1);
            efault = !e[0];
            frm = e[31:12];
        end else begin
            a1 = GT_BASE + 32'((DIR_SLOT + int'(va[30:22])) * 4);
            ea.push_back(a1);
            d = rdmem(a1);
            if (!d[0]) efault = 1'b1;
            else begin
                a2 = {d[31:12], va[21:12], 2'b00};
                ea.push_back(a2);
                e = rdmem(a2);
                efault = !e[0];
                frm = e[31:12];
            end
        end
        if (!hit) epa = efault ? 32'h0 : {frm, va[11:0]};
        lbl = (want != "") ? want : hit ? "R7" : resv ? "R5" : efault ? "R4" : mode ? "R3" : "R2";

        @(negedge clk);
        chk(req_ready, "R6", "ready before request", 64'(req_ready), 64'(1));
        rdq.delete();
        req_valid = 1'b1; req_va = va; req_mode = mode;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        busy_m = 1'b1;
        cyc = 0;
        while (!rsp_valid && cyc < 500) begin
            @(negedge clk);
            cyc++;
            flush = fl_mid && (cyc == 1);
        end
        flush = 1'b0;
        chk(rsp_valid, lbl, "response strobe", 64'(rsp_valid), 64'(1));
        chk(rsp_fault == efault, lbl, "fault flag", 64'(rsp_fault), 64'(efault));
        chk(rsp_pa == epa, lbl, "bus address", 64'(rsp_pa), 64'(epa));
        chk(rdq.size() == ea.size(), "R11", "read count", 64'(rdq.size()), 64'(ea.size()));
        for (int i = 0; i < ea.size() && i < rdq.size(); i++)
            chk(rdq[i] == ea[i], lbl, "table read address", 64'(rdq[i]), 64'(ea[i]));
        if (hit) chk(cyc == 1, "R7", "hit latency", 64'(cyc), 64'(1));
        @(negedge clk);
        busy_m = 1'b0;
        chk(!rsp_valid, "R6", "strobe one cycle", 64'(rsp_valid), 64'(0));
        chk(req_ready, "R6", "ready after response", 64'(req_ready), 64'(1));
        if (fl_mid) model_clear();
        if (!hit && !efault && !fl_mid) begin
            mtag[mptr] = tag; mfrm[mptr] = frm; mval[mptr] = 1'b1;
            mptr = (mptr + 1) % TLB_N;
        end
    endtask

    task automatic flush_idle();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        model_clear();
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    localparam logic [30:0] VA_G1 = 31'h0001_2345;
    localparam logic [30:0] VA_P1 = {9'd3, 10'd5, 12'h678};

    initial begin
        model_clear();
        // Global entries
        mem[GT_BASE + 32'h12 * 4]  = {20'hABCDE, 12'h001};
        mem[GT_BASE + 32'h13 * 4]  = {20'hFFFFF, 12'h000};
        mem[GT_BASE + 32'hC05 * 4] = {20'h55555, 12'h001};
        for (int i = 0; i < 6; i++)
            mem[GT_BASE + 32'((256 + i) * 4)] = {20'h30000 + 20'(i), 12'h001};
        // Directory entries: slot 3 valid, slot 7 invalid
        mem[GT_BASE + 32'((DIR_SLOT + 3) * 4)] = {20'h00400, 12'h001};
        mem[GT_BASE + 32'((DIR_SLOT + 7) * 4)] = {20'h00500, 12'h000};
        for (int i = 0; i < 16; i++)
            mem[32'h0040_0000 + 32'(i * 4)] = (i == 6) ? 32'h0 : {20'h60000 + 20'(i), 12'h001};
        mem[32'h0040_0014] = {20'h12345, 12'h001};

        repeat (3) @(negedge clk);
        chk(req_ready, "R1", "ready in reset", 64'(req_ready), 64'(1));
        chk(!rsp_valid, "R1", "no response in reset", 64'(rsp_valid), 64'(0));
        chk(!rd_req, "R1", "no read in reset", 64'(rd_req), 64'(0));
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !rd_req, "R1", "idle after reset",
            64'({req_ready, rsp_valid, rd_req}), 64'(3'b100));

        xlate(VA_G1, 1'b0, 1'b0, "R2");
        xlate(VA_P1, 1'b1, 1'b0, "R3");
        xlate(VA_P1, 1'b1, 1'b0, "R7");
        xlate({VA_P1[30:12], 12'h0AB}, 1'b1, 1'b0, "R7");
        xlate(VA_P1, 1'b0, 1'b0, "R7");
        xlate({9'd7, 10'd1, 12'h010}, 1'b1, 1'b0, "R4");
        xlate({9'd3, 10'd6, 12'h020}, 1'b1, 1'b0, "R4");
        xlate({9'd3, 10'd6, 12'h020}, 1'b1, 1'b0, "R7");
        xlate(31'h0001_3000, 1'b0, 1'b0, "R4");
        xlate(31'h7FE0_0000, 1'b0, 1'b0, "R5");
        xlate(31'h7FFF_FFFC, 1'b0, 1'b0, "R5");

        flush_idle();
        xlate(VA_G1, 1'b0, 1'b0, "R9");
        flush_idle();
        for (int i = 0; i < 5; i++)
            xlate(31'((256 + i) << 12) | 31'h44, 1'b0, 1'b0, "R8");
        xlate(31'(257 << 12), 1'b0, 1'b0, "R8");
        xlate(31'(256 << 12), 1'b0, 1'b0, "R8");

        xlate({9'd3, 10'd9, 12'h100}, 1'b1, 1'b1, "R10");
        xlate({9'd3, 10'd9, 12'h100}, 1'b1, 1'b0, "R10");
        xlate(31'(258 << 12), 1'b0, 1'b1, "R10");
        xlate(31'(258 << 12), 1'b0, 1'b0, "R10");

        for (int k = 0; k < 40; k++) begin
            if (k % 3 == 0)
                xlate(31'((256 + (k % 8)) << 12) | 31'(k * 5), 1'b0, 1'b0, "");
            else
                xlate({9'd3, 10'(k % 16), 12'(k * 37)}, 1'b1, 1'b0, "");
        end

        repeat (3) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule